// File: doc/BRIEF.md
# Precomputed-Slope Line Pixel Stepper

This block walks a straight raster line one pixel per clock and reports where each pixel lands in a word-organised bitmap. It does not work from endpoints. The caller supplies a 3-bit octant code that sets the major axis and both step signs. It also supplies the starting error term and the two error increments, the start word address and the bit position within that word, the row pitch in bytes, the pixel count, a 16-bit texture pattern and a one-pixel-per-row option.

After a start pulse, the block presents one pixel per cycle. Each pixel carries a byte address, a one-hot mask inside a 16-bit word and a pattern bit. The pixel is meant to be drawn only when the pattern bit is 1. A later stage does the memory read-modify-write. A busy flag covers the run, and a one-cycle done pulse marks its end. For a line with minor delta P and major delta G, the caller programs an initial error of 2P−G, a no-diagonal increment of 2P, a diagonal increment of 2P−2G and a count of G+1.

Top module: `line_stepper`

## Requirements
- R1: While rst_ni is low, and after its release until the first start, busy_o, done_o, pix_valid_o and pix_pat_o are 0.
- R2: octant_i[2]=1 selects X as the major axis; then octant_i[0]=1 means X decreasing and octant_i[1]=1 means Y increasing. octant_i[2]=0 selects Y as the major axis; then octant_i[0]=1 means Y increasing and octant_i[1]=1 means X decreasing. This maps the eight direction classes to codes 6,1,3,7,5,2,0,4.
- R3: After each pixel, a non-negative error moves one step on both axes and adds inc_step_i. A negative error moves only along the major axis and adds inc_nostep_i. The first decision uses err_init_i.
- R4: A start with nonzero len_i emits exactly len_i pixels. The last one is the line's end point.
- R5: The bit position counts from the word's MSB: position p gives pix_mask_o = 16'h8000 >> p. An X step moves p by one. Stepping past position 15 going right, or past position 0 going left, wraps p and changes the address by +2 or −2 bytes.
- R6: A Y step adds pitch_i to the address when Y increases, and subtracts it when Y decreases.
- R7: pix_pat_o is the MSB of a copy of pattern_i. The copy rotates left by one bit after every emitted pixel.
- R8: With one_per_row_i set at start, pix_pat_o is forced to 0 on every pixel except the first pixel of each row.
- R9: After the start edge, pixel i is presented during the cycle following edge i. busy_o and pix_valid_o are high exactly for those len_i cycles. done_o is high for the single cycle after the last pixel.
- R10: start_i is ignored while busy_o is high. All parameters are captured at start, so later input changes do not affect a run in progress.
- R11: A start with len_i = 0 emits no pixel, leaves busy_o low and raises done_o in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start pulse, taken only when idle |
| octant_i | input | 3 | Direction code: major axis and step signs |
| err_init_i | input | 16 | Initial signed error term (2P−G) |
| inc_nostep_i | input | 16 | Signed increment for a major-only step (2P) |
| inc_step_i | input | 16 | Signed increment for a diagonal step (2P−2G) |
| addr_i | input | 20 | Byte address of the word holding the first pixel |
| bit_i | input | 4 | Position of the first pixel in its word, 0 = MSB |
| pitch_i | input | 16 | Row pitch in bytes |
| len_i | input | 11 | Number of pixels to emit |
| pattern_i | input | 16 | Texture pattern, MSB used first |
| one_per_row_i | input | 1 | Allow at most one drawn pixel per row |
| busy_o | output | 1 | Run in progress |
| done_o | output | 1 | One-cycle end-of-run pulse |
| pix_valid_o | output | 1 | A pixel is presented this cycle |
| pix_addr_o | output | 20 | Byte address of the pixel's word |
| pix_mask_o | output | 16 | One-hot pixel mask inside the word |
| pix_pat_o | output | 1 | Draw enable for the pixel |

## Verification
A wrong error register or a wrong increment changes the minor-axis step, so the address or mask departs from the reference path at the first wrong decision and the error grows until the end point. A wrong decoded direction shows up on the second pixel. A wrong bit-position wrap shows up as a bad address on the first pixel after a word boundary. Count or pattern faults show up as a busy/done edge off by a cycle, or as a pixel whose draw enable is inverted. Comparing every pixel against a walk over integer coordinates therefore locates the fault cycle exactly.

// File: rtl/line_pkg.sv
package line_pkg;
  typedef struct packed {
    logic major_x;
    logic x_neg;
    logic y_pos;
  } line_dir_t;

  typedef enum logic {ST_IDLE, ST_RUN} line_state_t;
endpackage

// File: rtl/line_octant_dec.sv
module line_octant_dec
  import line_pkg::*;
(
  input  logic [2:0] code_i,
  output line_dir_t  dir_o
);
  // [2]: X major; meaning of [1]/[0] swaps with the major axis
  always_comb begin
    dir_o.major_x = code_i[2];
    dir_o.x_neg   = code_i[2] ? code_i[0] : code_i[1];
    dir_o.y_pos   = code_i[2] ? code_i[1] : code_i[0];
  end
endmodule

// File: rtl/line_err_step.sv
module line_err_step #(
  parameter int EW = 16
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 load_i,
  input  logic                 adv_i,
  input  logic signed [EW-1:0] err_init_i,
  input  logic signed [EW-1:0] inc_nostep_i,
  input  logic signed [EW-1:0] inc_step_i,
  output logic                 diag_o
);
  logic signed [EW-1:0] err_q, ns_q, st_q;

  assign diag_o = ~err_q[EW-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      err_q <= '0;
      ns_q  <= '0;
      st_q  <= '0;
    end else if (load_i) begin
      err_q <= err_init_i;
      ns_q  <= inc_nostep_i;
      st_q  <= inc_step_i;
    end else if (adv_i) begin
      err_q <= err_q + (diag_o ? st_q : ns_q);
    end
  end
endmodule

// File: rtl/line_pos_step.sv
module line_pos_step
  import line_pkg::*;
#(
  parameter int AW = 20,
  parameter int PW = 16,
  parameter int DW = 16,
  localparam int BW = $clog2(DW)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic          adv_i,
  input  logic [AW-1:0] addr_i,
  input  logic [BW-1:0] bit_i,
  input  logic [PW-1:0] pitch_i,
  input  line_dir_t     dir_i,
  input  logic          diag_i,
  output logic [AW-1:0] addr_o,
  output logic [BW-1:0] bit_o,
  output logic          row_step_o
);
  localparam int STEP = DW / 8;

  logic [AW-1:0] addr_q, pitch_q, addr_n;
  logic [BW-1:0] bit_q, bit_n;
  line_dir_t     dir_q;
  logic          x_mv, y_mv, at_edge;

  always_comb begin
    x_mv    = dir_q.major_x | diag_i;
    y_mv    = ~dir_q.major_x | diag_i;
    at_edge = dir_q.x_neg ? (bit_q == '0) : (bit_q == BW'(DW - 1));
    bit_n   = bit_q;
    addr_n  = addr_q;
    if (x_mv) begin
      // DW is a power of two: position wraps on its own
      bit_n = dir_q.x_neg ? bit_q - 1'b1 : bit_q + 1'b1;
      if (at_edge)
        addr_n = dir_q.x_neg ? addr_n - AW'(STEP) : addr_n + AW'(STEP);
    end
    if (y_mv)
      addr_n = dir_q.y_pos ? addr_n + pitch_q : addr_n - pitch_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q  <= '0;
      pitch_q <= '0;
      bit_q   <= '0;
      dir_q   <= '0;
    end else if (load_i) begin
      addr_q  <= addr_i;
      pitch_q <= AW'(pitch_i);
      bit_q   <= bit_i;
      dir_q   <= dir_i;
    end else if (adv_i) begin
      addr_q  <= addr_n;
      bit_q   <= bit_n;
    end
  end

  assign addr_o     = addr_q;
  assign bit_o      = bit_q;
  assign row_step_o = y_mv;
endmodule

// File: rtl/line_stepper.sv
module line_stepper
  import line_pkg::*;
#(
  parameter int EW = 16,
  parameter int AW = 20,
  parameter int PW = 16,
  parameter int LW = 11,
  parameter int DW = 16,
  localparam int BW = $clog2(DW)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 start_i,
  input  logic [2:0]           octant_i,
  input  logic signed [EW-1:0] err_init_i,
  input  logic signed [EW-1:0] inc_nostep_i,
  input  logic signed [EW-1:0] inc_step_i,
  input  logic [AW-1:0]        addr_i,
  input  logic [BW-1:0]        bit_i,
  input  logic [PW-1:0]        pitch_i,
  input  logic [LW-1:0]        len_i,
  input  logic [DW-1:0]        pattern_i,
  input  logic                 one_per_row_i,
  output logic                 busy_o,
  output logic                 done_o,
  output logic                 pix_valid_o,
  output logic [AW-1:0]        pix_addr_o,
  output logic [DW-1:0]        pix_mask_o,
  output logic                 pix_pat_o
);
  line_state_t   state_q;
  logic [LW-1:0] cnt_q;
  logic [DW-1:0] pat_q;
  logic          row_new_q, opr_q, done_q;
  logic          load, adv, diag, row_step;
  logic [BW-1:0] bit_pos;
  line_dir_t     dir;

  assign load = start_i & (state_q == ST_IDLE) & (len_i != '0);
  assign adv  = (state_q == ST_RUN);

  line_octant_dec i_dec (
    .code_i (octant_i),
    .dir_o  (dir)
  );

  line_err_step #(.EW(EW)) i_err (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .load_i       (load),
    .adv_i        (adv),
    .err_init_i   (err_init_i),
    .inc_nostep_i (inc_nostep_i),
    .inc_step_i   (inc_step_i),
    .diag_o       (diag)
  );

  line_pos_step #(.AW(AW), .PW(PW), .DW(DW)) i_pos (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (load),
    .adv_i      (adv),
    .addr_i     (addr_i),
    .bit_i      (bit_i),
    .pitch_i    (pitch_i),
    .dir_i      (dir),
    .diag_i     (diag),
    .addr_o     (pix_addr_o),
    .bit_o      (bit_pos),
    .row_step_o (row_step)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      cnt_q     <= '0;
      pat_q     <= '0;
      row_new_q <= 1'b0;
      opr_q     <= 1'b0;
      done_q    <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (state_q == ST_IDLE) begin
        if (start_i) begin
          if (len_i == '0) begin
            done_q <= 1'b1;
          end else begin
            state_q   <= ST_RUN;
            cnt_q     <= len_i;
            pat_q     <= pattern_i;
            row_new_q <= 1'b1;
            opr_q     <= one_per_row_i;
          end
        end
      end else begin
        cnt_q     <= cnt_q - 1'b1;
        pat_q     <= {pat_q[DW-2:0], pat_q[DW-1]};
        row_new_q <= row_step;
        if (cnt_q == LW'(1)) begin
          state_q <= ST_IDLE;
          done_q  <= 1'b1;
        end
      end
    end
  end

  assign busy_o      = (state_q == ST_RUN);
  assign pix_valid_o = (state_q == ST_RUN);
  assign done_o      = done_q;
  assign pix_mask_o  = {1'b1, {(DW-1){1'b0}}} >> bit_pos;
  assign pix_pat_o   = pix_valid_o & pat_q[DW-1] & (~opr_q | row_new_q);
endmodule

// File: rtl/line_stepper_chk.sv
module line_stepper_chk #(
  parameter int LW = 11,
  parameter int DW = 16
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          start_i,
  input logic [LW-1:0] len_i,
  input logic          busy_o,
  input logic          done_o,
  input logic          pix_valid_o,
  input logic [DW-1:0] pix_mask_o,
  input logic          pix_pat_o
);
  p_load_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o && len_i != '0) |=> (busy_o && pix_valid_o));

  p_zero_len_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o && len_i == '0) |=> (done_o && !busy_o));

  p_busy_end_done_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> done_o);

  p_done_idle_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);

  p_start_ignored_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && start_i) |=> (busy_o || done_o));

  p_mask_onehot_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pix_valid_o |-> ($countones(pix_mask_o) == 1));

  p_pat_gate_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pix_pat_o |-> pix_valid_o);
endmodule

bind line_stepper line_stepper_chk #(.LW(LW), .DW(DW)) i_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .start_i     (start_i),
  .len_i       (len_i),
  .busy_o      (busy_o),
  .done_o      (done_o),
  .pix_valid_o (pix_valid_o),
  .pix_mask_o  (pix_mask_o),
  .pix_pat_o   (pix_pat_o)
);

// File: tb/test_line_stepper.sv
`timescale 1ns/1ps
module test_line_stepper;
  localparam int BASE  = 'h1000;
  localparam int PITCH = 40;

  logic               clk_i = 1'b0;
  logic               rst_ni = 1'b1;
  logic               start_i = 1'b0;
  logic [2:0]         octant_i = '0;
  logic signed [15:0] err_init_i = '0;
  logic signed [15:0] inc_nostep_i = '0;
  logic signed [15:0] inc_step_i = '0;
  logic [19:0]        addr_i = '0;
  logic [3:0]         bit_i = '0;
  logic [15:0]        pitch_i = 16'(PITCH);
  logic [10:0]        len_i = '0;
  logic [15:0]        pattern_i = '0;
  logic               one_per_row_i = 1'b0;
  logic               busy_o, done_o, pix_valid_o, pix_pat_o;
  logic [19:0]        pix_addr_o;
  logic [15:0]        pix_mask_o;

  int n_chk = 0;
  int n_bad = 0;

  always #4 clk_i = ~clk_i;

  line_stepper i_line_stepper (.*);

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  function automatic int exp_addr(input int x, input int y);
    return BASE + y * PITCH + (x / 16) * 2;
  endfunction

  task automatic t_reset();
    rst_ni = 1'b0;
    repeat (2) @(negedge clk_i);
    chk(!busy_o && !done_o && !pix_valid_o && !pix_pat_o, "R1 in reset",
        {busy_o, done_o, pix_valid_o, pix_pat_o}, 0);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);
    chk(!busy_o && !done_o && !pix_valid_o && !pix_pat_o, "R1 after release",
        {busy_o, done_o, pix_valid_o, pix_pat_o}, 0);
  endtask

  // Draw (x1,y1)->(x2,y2); poke re-asserts start with bogus inputs mid-run
  task automatic t_line(input int x1, input int y1, input int x2, input int y2,
                        input logic [15:0] pat, input bit opr, input bit poke);
    int dx, dy, p, g, sx, sy, x, y, err, prev_y;
    bit xmaj, xneg, yneg;
    logic [2:0] code;
    logic [15:0] pr;
    bit path_ok;
    xneg = x2 < x1;
    yneg = y2 < y1;
    dx = xneg ? x1 - x2 : x2 - x1;
    dy = yneg ? y1 - y2 : y2 - y1;
    xmaj = dx >= dy;
    g = xmaj ? dx : dy;
    p = xmaj ? dy : dx;
    sx = xneg ? -1 : 1;
    sy = yneg ? -1 : 1;
    if (xmaj) code = !xneg ? (!yneg ? 3'd6 : 3'd4) : (!yneg ? 3'd7 : 3'd5);
    else      code = !xneg ? (!yneg ? 3'd1 : 3'd0) : (!yneg ? 3'd3 : 3'd2);

    @(negedge clk_i);
    octant_i      = code;
    err_init_i    = 16'(2 * p - g);
    inc_nostep_i  = 16'(2 * p);
    inc_step_i    = 16'(2 * p - 2 * g);
    addr_i        = 20'(exp_addr(x1, y1));
    bit_i         = 4'(x1 % 16);
    len_i         = 11'(g + 1);
    pattern_i     = pat;
    one_per_row_i = opr;
    start_i       = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;

    x = x1; y = y1; err = 2 * p - g; pr = pat; prev_y = y1; path_ok = 1'b1;
    for (int i = 0; i <= g; i++) begin
      logic exp_pat;
      exp_pat = pr[15] & (!opr | (i == 0) | (y != prev_y));
      chk(busy_o && pix_valid_o, "R9 busy/valid during pixel", {busy_o, pix_valid_o}, 3);
      chk(pix_addr_o == 20'(exp_addr(x, y)), "R3/R6 pixel address", pix_addr_o, exp_addr(x, y));
      chk(pix_mask_o == (16'h8000 >> (x % 16)), "R5 pixel mask", pix_mask_o, 16'h8000 >> (x % 16));
      chk(pix_pat_o == exp_pat, opr ? "R8 one-per-row enable" : "R7 pattern bit", pix_pat_o, exp_pat);
      if (pix_addr_o != 20'(exp_addr(x, y)) || pix_mask_o != (16'h8000 >> (x % 16))) path_ok = 1'b0;
      prev_y = y;
      pr = {pr[14:0], pr[15]};
      if (err >= 0) begin
        x += sx; y += sy; err += 2 * p - 2 * g;
      end else begin
        if (xmaj) x += sx; else y += sy;
        err += 2 * p;
      end
      if (poke && i == 1) begin
        octant_i = ~code; len_i = 11'd3; pattern_i = ~pat; addr_i = '0; start_i = 1'b1;
      end
      @(negedge clk_i);
      start_i = 1'b0;
    end
    chk(path_ok, "R2 direction code path", path_ok, 1);
    chk(!busy_o && !pix_valid_o && done_o, "R4/R9 end after len pixels",
        {busy_o, pix_valid_o, done_o}, 1);
    @(negedge clk_i);
    chk(!done_o && !busy_o, poke ? "R10 no restart after ignored start" : "R9 done single cycle",
        {done_o, busy_o}, 0);
  endtask

  task automatic t_zero_len();
    @(negedge clk_i);
    len_i = '0; start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    chk(done_o && !busy_o && !pix_valid_o, "R11 zero length done",
        {done_o, busy_o, pix_valid_o}, 4);
    @(negedge clk_i);
    chk(!done_o && !busy_o && !pix_valid_o, "R11 zero length quiet",
        {done_o, busy_o, pix_valid_o}, 0);
  endtask

  initial begin
    #(8 * 200000);
    n_chk++; n_bad++;
    $display("FAIL R9 watchdog: actual hung expected finished");
    summary();
    $finish;
  end

  initial begin
    t_reset();
    // R2: one line per direction class, several crossing word boundaries (R5)
    t_line(100, 50, 130, 60, 16'hFFFF, 1'b0, 1'b0);
    t_line(100, 50, 105, 80, 16'hFFFF, 1'b0, 1'b0);
    t_line(100, 50,  90, 80, 16'hFFFF, 1'b0, 1'b0);
    t_line(100, 50,  60, 55, 16'hFFFF, 1'b0, 1'b0);
    t_line(100, 80,  70, 70, 16'hFFFF, 1'b0, 1'b0);
    t_line(100, 80,  95, 40, 16'hFFFF, 1'b0, 1'b0);
    t_line(100, 80, 106, 50, 16'hFFFF, 1'b0, 1'b0);
    t_line(100, 80, 140, 75, 16'hFFFF, 1'b0, 1'b0);
    // R3 diagonal, horizontal, vertical; R4 single pixel
    t_line(10, 10, 30, 30, 16'hFFFF, 1'b0, 1'b0);
    t_line(0, 5, 40, 5, 16'hFFFF, 1'b0, 1'b0);
    t_line(200, 90, 200, 60, 16'hFFFF, 1'b0, 1'b0);
    t_line(50, 50, 50, 50, 16'hFFFF, 1'b0, 1'b0);
    // R7 dashed pattern
    t_line(10, 100, 60, 110, 16'hFF00, 1'b0, 1'b0);
    t_line(250, 20, 230, 45, 16'hA5C3, 1'b0, 1'b0);
    // R8 one pixel per row, X-major and Y-major
    t_line(20, 120, 80, 130, 16'hFFFF, 1'b1, 1'b0);
    t_line(80, 140, 60, 120, 16'hFFFF, 1'b1, 1'b0);
    // R10 start ignored while busy
    t_line(100, 50, 130, 60, 16'hF0F0, 1'b0, 1'b1);
    t_zero_len();
    summary();
    $finish;
  end
endmodule